// File: doc/BRIEF.md
# Dual-Request Data Cache Bank Arbiter

This block sits at the front of a data cache that receives two load/store requests in the same cycle, one from the primary integer pipe and one from the secondary integer pipe. The tag side can serve both requests at once. The data side is split into single-ported banks, and consecutive 32-bit words of a line fall into different banks. The arbiter works out which bank each request selects and drives one enable, one write strobe and one row address per bank.

When the two requests select different banks, both are granted in the same cycle. When they select the same bank, the primary pipe always wins. The secondary request is parked in a one-entry replay slot and stalled, and it is retried in the next cycle ahead of anything new on the secondary port. There is one exception: two reads of exactly the same word are both granted, so they share one bank read. All outputs are registered. The decision made on the inputs sampled at one rising edge shows up on the outputs just after that edge.

Top module: `dcb_bank_arbiter`

## Requirements
- R1: The bank of a request is address bits [4:2], giving eight banks of 32-bit words. The row driven on that bank's address output is address bits [ADDR_W-1:5]. The reported bank for each pipe is that bank number.
- R2: Outputs are registered: the decision for inputs sampled at a rising edge appears on the outputs after that edge. A synchronous active-high reset clears every grant, stall, bank enable and write strobe, and empties the replay slot.
- R3: A valid primary request is always granted, on the cycle after it is sampled.
- R4: Two valid requests that select different banks are both granted in the same cycle.
- R5: Two valid requests that select the same bank conflict unless both are reads of the same word. In a conflict the primary request is granted, the secondary gets no grant, and s_stall is high for the following cycle. s_grant and s_stall are never both high.
- R6: Two valid reads of the same word are both granted, with a single bank enable and its write strobe low.
- R7: While s_stall is high, the secondary port inputs are ignored. The parked request is retried in place of them and is granted unless it collides again with a new primary request, in which case it stays parked.
- R8: A request whose valid is low never causes a conflict, enables no bank and receives no grant. With no valid primary request, s_stall is low on the next cycle.
- R9: An enabled bank's write strobe equals the write flag of the request granted to it. A disabled bank has its write strobe low.
- R10: The set of enabled banks is exactly the set of banks of the granted requests, so at most two banks are enabled in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_valid | input | 1 | Primary pipe request valid |
| p_addr | input | ADDR_W | Primary pipe byte address |
| p_write | input | 1 | Primary pipe request is a store |
| s_valid | input | 1 | Secondary pipe request valid |
| s_addr | input | ADDR_W | Secondary pipe byte address |
| s_write | input | 1 | Secondary pipe request is a store |
| p_grant | output | 1 | Primary request granted this cycle |
| s_grant | output | 1 | Secondary (new or replayed) request granted this cycle |
| s_stall | output | 1 | Secondary request parked; secondary inputs ignored this cycle |
| p_bank | output | BANK_W | Bank serving the primary grant |
| s_bank | output | BANK_W | Bank serving the secondary grant |
| bank_en | output | NUM_BANKS | Per-bank enable |
| bank_we | output | NUM_BANKS | Per-bank write strobe |
| bank_addr | output | NUM_BANKS x ROW_W | Per-bank row address |

## Verification
The assertions check the following on every cycle:
- A sampled primary request is granted on the next cycle.
- A grant and a stall never coincide.
- A shared bank is only ever shared by two reads.
- The count of enabled banks agrees with the grants.
- A missing primary request leaves no stall behind.
- A parked request with no primary competitor is granted on the next cycle.

Other behaviour needs the bench's reference model and scenarios. This covers the exact bank and row decoding, whether a pair of requests counts as a conflict or a shared read, that new secondary inputs are ignored during a stall, and the case where a replayed request collides again.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  // Which pipe owns a bank in a given cycle.
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_PRI  = 2'd1,
    OWN_SEC  = 2'd2,
    OWN_BOTH = 2'd3
  } bank_owner_e;
endpackage

// File: rtl/dcb_req_decode.sv
module dcb_req_decode #(
  parameter int ADDR_W     = 16,
  parameter int NUM_BANKS  = 8,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W  = $clog2(WORD_BYTES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROW_W  = ADDR_W - OFF_W - BANK_W,
  localparam int WORD_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [WORD_W-1:0] word
);
  // Word-interleaved banks: low word bits pick the bank, the rest pick the row.
  assign word = addr[ADDR_W-1:OFF_W];
  assign bank = addr[OFF_W +: BANK_W];
  assign row  = addr[ADDR_W-1:OFF_W+BANK_W];
endmodule

// File: rtl/dcb_conflict_cmp.sv
module dcb_conflict_cmp #(
  parameter int BANK_W = 3,
  parameter int WORD_W = 14
) (
  input  logic              p_vld,
  input  logic              p_wr,
  input  logic [BANK_W-1:0] p_bank,
  input  logic [WORD_W-1:0] p_word,
  input  logic              s_vld,
  input  logic              s_wr,
  input  logic [BANK_W-1:0] s_bank,
  input  logic [WORD_W-1:0] s_word,
  output logic              conflict,
  output logic              shared
);
  logic both_vld;
  logic same_bank;
  logic read_pair_same_word;

  assign both_vld            = p_vld & s_vld;
  assign same_bank           = (p_bank == s_bank);
  assign read_pair_same_word = ~p_wr & ~s_wr & (p_word == s_word);

  assign shared   = both_vld & same_bank & read_pair_same_word;
  assign conflict = both_vld & same_bank & ~read_pair_same_word;
endmodule

// File: rtl/dcb_replay_slot.sv
module dcb_replay_slot #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_wr,
  input  logic              park,
  output logic              eff_vld,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              eff_wr,
  output logic              held
);
  logic              hold_vld;
  logic [ADDR_W-1:0] hold_addr;
  logic              hold_wr;

  // A parked request replaces the secondary port until it is served.
  assign eff_vld  = hold_vld ? 1'b1      : in_vld;
  assign eff_addr = hold_vld ? hold_addr : in_addr;
  assign eff_wr   = hold_vld ? hold_wr   : in_wr;
  assign held     = hold_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_addr <= '0;
      hold_wr   <= 1'b0;
    end else begin
      hold_vld <= park;
      if (park) begin
        hold_addr <= eff_addr;
        hold_wr   <= eff_wr;
      end
    end
  end
endmodule

// File: rtl/dcb_bank_route.sv
module dcb_bank_route
  import dcb_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 11,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                             p_go,
  input  logic                             p_wr,
  input  logic [BANK_W-1:0]                p_bank,
  input  logic [ROW_W-1:0]                 p_row,
  input  logic                             s_go,
  input  logic                             s_wr,
  input  logic [BANK_W-1:0]                s_bank,
  input  logic [ROW_W-1:0]                 s_row,
  output logic [NUM_BANKS-1:0]             en,
  output logic [NUM_BANKS-1:0]             we,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  row
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_owner_e owner;
    logic        p_hit;
    logic        s_hit;

    assign p_hit = p_go & (p_bank == BANK_W'(b));
    assign s_hit = s_go & (s_bank == BANK_W'(b));
    assign owner = bank_owner_e'({s_hit, p_hit});

    always_comb begin
      en[b]  = 1'b0;
      we[b]  = 1'b0;
      row[b] = '0;
      unique case (owner)
        OWN_PRI, OWN_BOTH: begin
          en[b]  = 1'b1;
          we[b]  = p_wr;
          row[b] = p_row;
        end
        OWN_SEC: begin
          en[b]  = 1'b1;
          we[b]  = s_wr;
          row[b] = s_row;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dcb_bank_arbiter.sv
module dcb_bank_arbiter #(
  parameter int ADDR_W     = 16,
  parameter int NUM_BANKS  = 8,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W  = $clog2(WORD_BYTES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROW_W  = ADDR_W - OFF_W - BANK_W,
  localparam int WORD_W = ADDR_W - OFF_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            p_valid,
  input  logic [ADDR_W-1:0]               p_addr,
  input  logic                            p_write,
  input  logic                            s_valid,
  input  logic [ADDR_W-1:0]               s_addr,
  input  logic                            s_write,
  output logic                            p_grant,
  output logic                            s_grant,
  output logic                            s_stall,
  output logic [BANK_W-1:0]               p_bank,
  output logic [BANK_W-1:0]               s_bank,
  output logic [NUM_BANKS-1:0]            bank_en,
  output logic [NUM_BANKS-1:0]            bank_we,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] bank_addr
);
  // Effective secondary request (replay slot or port)
  logic              sec_vld;
  logic [ADDR_W-1:0] sec_addr;
  logic              sec_wr;
  logic              sec_held;

  // Decoded fields
  logic [BANK_W-1:0] pri_bank_d, sec_bank_d;
  logic [ROW_W-1:0]  pri_row_d,  sec_row_d;
  logic [WORD_W-1:0] pri_word_d, sec_word_d;

  logic conflict;
  logic shared;
  logic pri_go;
  logic sec_go;
  logic park;

  logic [NUM_BANKS-1:0]            en_d;
  logic [NUM_BANKS-1:0]            we_d;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_d;

  dcb_replay_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (s_valid),
    .in_addr  (s_addr),
    .in_wr    (s_write),
    .park     (park),
    .eff_vld  (sec_vld),
    .eff_addr (sec_addr),
    .eff_wr   (sec_wr),
    .held     (sec_held)
  );

  dcb_req_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .WORD_BYTES(WORD_BYTES)
  ) u_dec_pri (
    .addr (p_addr),
    .bank (pri_bank_d),
    .row  (pri_row_d),
    .word (pri_word_d)
  );

  dcb_req_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .WORD_BYTES(WORD_BYTES)
  ) u_dec_sec (
    .addr (sec_addr),
    .bank (sec_bank_d),
    .row  (sec_row_d),
    .word (sec_word_d)
  );

  dcb_conflict_cmp #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_cmp (
    .p_vld    (p_valid),
    .p_wr     (p_write),
    .p_bank   (pri_bank_d),
    .p_word   (pri_word_d),
    .s_vld    (sec_vld),
    .s_wr     (sec_wr),
    .s_bank   (sec_bank_d),
    .s_word   (sec_word_d),
    .conflict (conflict),
    .shared   (shared)
  );

  // Primary always wins; the secondary loses only on a real conflict.
  assign pri_go = p_valid;
  assign sec_go = sec_vld & ~conflict;
  assign park   = sec_vld & conflict;

  dcb_bank_route #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_route (
    .p_go   (pri_go),
    .p_wr   (p_write),
    .p_bank (pri_bank_d),
    .p_row  (pri_row_d),
    .s_go   (sec_go),
    .s_wr   (sec_wr),
    .s_bank (sec_bank_d),
    .s_row  (sec_row_d),
    .en     (en_d),
    .we     (we_d),
    .row    (row_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p_grant   <= 1'b0;
      s_grant   <= 1'b0;
      s_stall   <= 1'b0;
      p_bank    <= '0;
      s_bank    <= '0;
      bank_en   <= '0;
      bank_we   <= '0;
      bank_addr <= '0;
    end else begin
      p_grant   <= pri_go;
      s_grant   <= sec_go;
      s_stall   <= park;
      p_bank    <= pri_bank_d;
      s_bank    <= sec_bank_d;
      bank_en   <= en_d;
      bank_we   <= we_d;
      bank_addr <= row_d;
    end
  end
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker #(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 p_valid,
  input logic                 p_grant,
  input logic                 s_grant,
  input logic                 s_stall,
  input logic [BANK_W-1:0]    p_bank,
  input logic [BANK_W-1:0]    s_bank,
  input logic [NUM_BANKS-1:0] bank_en,
  input logic [NUM_BANKS-1:0] bank_we
);
  AST_PRI_ALWAYS_WINS: assert property (@(posedge clk) disable iff (rst)
    p_valid |=> p_grant); // R3

  AST_GRANT_XOR_STALL: assert property (@(posedge clk) disable iff (rst)
    !(s_grant && s_stall)); // R5

  AST_SHARE_ONLY_READS: assert property (@(posedge clk) disable iff (rst)
    (p_grant && s_grant && (p_bank == s_bank)) |-> !bank_we[p_bank]); // R6

  AST_REPLAY_UNOPPOSED: assert property (@(posedge clk) disable iff (rst)
    (s_stall && !p_valid) |=> s_grant); // R7

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    !p_valid |=> !s_stall); // R8

  AST_EN_MATCHES_GRANTS: assert property (@(posedge clk) disable iff (rst)
    ($countones(bank_en) <= 2) && ((bank_en != '0) == (p_grant || s_grant))); // R10

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (bank_we & ~bank_en) == '0); // R9
endmodule

bind dcb_bank_arbiter dcb_checker #(.NUM_BANKS(NUM_BANKS)) u_dcb_checker (
  .clk     (clk),
  .rst     (rst),
  .p_valid (p_valid),
  .p_grant (p_grant),
  .s_grant (s_grant),
  .s_stall (s_stall),
  .p_bank  (p_bank),
  .s_bank  (s_bank),
  .bank_en (bank_en),
  .bank_we (bank_we)
);

// File: tb/test_dcb_bank_arbiter.sv
module test_dcb_bank_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int NB         = 8;
  localparam int BANK_W     = 3;
  localparam int ROW_W      = ADDR_W - 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic p_valid = 1'b0, p_write = 1'b0, s_valid = 1'b0, s_write = 1'b0;
  logic [ADDR_W-1:0] p_addr = '0, s_addr = '0;
  logic p_grant, s_grant, s_stall;
  logic [BANK_W-1:0] p_bank, s_bank;
  logic [NB-1:0] bank_en, bank_we;
  logic [NB-1:0][ROW_W-1:0] bank_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state: one parked secondary request.
  bit                m_hv = 1'b0;
  logic [ADDR_W-1:0] m_ha = '0;
  bit                m_hw = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcb_bank_arbiter #(.ADDR_W(ADDR_W), .NUM_BANKS(NB), .WORD_BYTES(4)) i_dcb_bank_arbiter (
    .clk(clk), .rst(rst),
    .p_valid(p_valid), .p_addr(p_addr), .p_write(p_write),
    .s_valid(s_valid), .s_addr(s_addr), .s_write(s_write),
    .p_grant(p_grant), .s_grant(s_grant), .s_stall(s_stall),
    .p_bank(p_bank), .s_bank(s_bank),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr)
  );

  // One cycle: drive at negedge, predict, cross the edge, compare at next negedge.
  task automatic step(input bit pv, input logic [ADDR_W-1:0] pa, input bit pw,
                      input bit sv, input logic [ADDR_W-1:0] sa, input bit sw,
                      input string tag);
    bit ev, ew, conf, e_pg, e_sg, e_st, bad;
    logic [ADDR_W-1:0] ea;
    int pb, sb;
    logic [NB-1:0] e_en, e_we;
    logic [NB-1:0][ROW_W-1:0] e_row;
    p_valid = pv; p_addr = pa; p_write = pw;
    s_valid = sv; s_addr = sa; s_write = sw;
    ev = m_hv ? 1'b1 : sv;
    ea = m_hv ? m_ha : sa;
    ew = m_hv ? m_hw : sw;
    pb = int'(pa[4:2]);
    sb = int'(ea[4:2]);
    conf = pv && ev && (pb == sb) && !(!pw && !ew && (pa[ADDR_W-1:2] == ea[ADDR_W-1:2]));
    e_pg = pv;
    e_sg = ev && !conf;
    e_st = ev && conf;
    if (conf) begin m_hv = 1'b1; m_ha = ea; m_hw = ew; end
    else m_hv = 1'b0;
    e_en = '0; e_we = '0; e_row = '0;
    if (e_sg) begin e_en[sb] = 1'b1; e_we[sb] = ew; e_row[sb] = ea[ADDR_W-1:5]; end
    if (e_pg) begin e_en[pb] = 1'b1; e_we[pb] = pw; e_row[pb] = pa[ADDR_W-1:5]; end
    @(posedge clk);
    @(negedge clk);
    bad = (p_grant !== e_pg) || (s_grant !== e_sg) || (s_stall !== e_st) ||
          (bank_en !== e_en) || (bank_we !== e_we);
    if (e_pg && (int'(p_bank) != pb)) bad = 1'b1;
    if (e_sg && (int'(s_bank) != sb)) bad = 1'b1;
    for (int b = 0; b < NB; b++)
      if (e_en[b] && (bank_addr[b] !== e_row[b])) bad = 1'b1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: got pg=%0b sg=%0b st=%0b en=%b we=%b pb=%0d sb=%0d, expected pg=%0b sg=%0b st=%0b en=%b we=%b pb=%0d sb=%0d",
               tag, p_grant, s_grant, s_stall, bank_en, bank_we, p_bank, s_bank,
               e_pg, e_sg, e_st, e_en, e_we, pb, sb);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected run to finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R2: reset state
    checks++;
    if (p_grant !== 1'b0 || s_grant !== 1'b0 || s_stall !== 1'b0 || bank_en !== '0 || bank_we !== '0) begin
      errors++;
      $display("FAIL R2 reset: got pg=%0b sg=%0b st=%0b en=%b we=%b, expected all zero",
               p_grant, s_grant, s_stall, bank_en, bank_we);
    end
    rst = 1'b0;

    // R1/R4: different banks, distinct rows
    step(1, 16'h0124, 0, 1, 16'h03F8, 0, "R1_R4 diff banks");
    step(1, 16'h001C, 1, 1, 16'h0000, 1, "R4_R9 two writes diff banks");
    // R5: same bank, different word -> stall
    step(1, 16'h0000, 0, 1, 16'h0020, 0, "R5 same bank conflict");
    // R7: stalled, new secondary ignored, replay granted
    step(0, 16'h0000, 0, 1, 16'h0004, 0, "R7 replay with new sec ignored");
    // R6: same word reads shared
    step(1, 16'h0108, 0, 1, 16'h0108, 0, "R6 shared read");
    // R5: same word with a write conflicts
    step(1, 16'h0108, 1, 1, 16'h0108, 0, "R5 same word write conflict");
    // R7: replay collides again with a new primary and stays parked
    step(1, 16'h0208, 0, 1, 16'h0010, 0, "R7 replay collides again");
    step(1, 16'h0010, 0, 1, 16'h0014, 1, "R7_R9 replay granted next");
    // R8: invalid requests
    step(0, 16'h0040, 1, 1, 16'h0040, 0, "R8 invalid primary");
    step(1, 16'h0040, 0, 0, 16'h0040, 1, "R8 invalid secondary");
    step(0, 16'h0000, 0, 0, 16'h0000, 0, "R8 idle");
    // R3/R10: random stream with dense bank collisions
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a1, a2;
      a1 = ADDR_W'({$urandom_range(0, 3), 3'($urandom_range(0, 7)), 2'b00});
      a2 = ADDR_W'({$urandom_range(0, 3), 3'($urandom_range(0, 7)), 2'b00});
      step(bit'($urandom_range(0, 3) != 0), a1, bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 3) != 0), a2, bit'($urandom_range(0, 1)),
           "R3_R10 random");
    end
    // R2: reset mid-stream clears the parked request
    step(1, 16'h0000, 0, 1, 16'h0020, 0, "R5 conflict before reset");
    rst = 1'b1;
    m_hv = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(0, 16'h0000, 0, 0, 16'h0000, 0, "R2 slot emptied by reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule